// File: doc/BRIEF.md
# Configurable Crosspoint I/O Cell

One cell of a programmable digital crosspoint fabric. The cell sends one of four routed candidate signals to its pad. The choice comes from a run-time select, not only from the configuration. Each candidate position is wired to its own input group. The cell also exports its local 4:1 result. Four cells can then form a 16:1 multiplexer: in cascade mode the upper two select bits pick which cell's local result is forwarded.

The path from the pad into the routing fabric and the path from the routing result out to the pad are configured separately. Each path is combinational, latch-like (follows its data while its enable is high, holds while it is low) or registered (captures on a rising edge when enabled). Each path's enable comes from one of four global enable lines or from an enable derived from an I/O pin. A fixed-level option drives the pad with a constant, which stands in for a jumper or DIP switch. The output-enable polarity is selectable. The pad stays undriven through reset and until the configuration is flagged complete.

Top module: `xpt_io_cell`

## Requirements
- R1: With cascade off, the routed value is `grp_in[sel]`: bit 0 is group A, bit 1 is B, bit 2 is C, bit 3 is D. `casc_out` always carries `grp_in[sel]`.
- R2: With `cfg_casc_en`=1, the routed value is `casc_in[casc_sel]` in place of the local result.
- R3: Path mode 2'b00 (and the unused code 2'b11) is combinational: the path output equals its data input in the same cycle.
- R4: Path mode 2'b01 is latch-like. When the path enable is high, the output equals its data input in the same cycle. When the enable is low, the output holds the value that was last stored.
- R5: Path mode 2'b10 is registered. The output shows the stored value. The store takes the data input at a rising edge when the path enable is high and keeps its value otherwise.
- R6: The input path (from `pad_in` to `in_to_grp`) follows R3 to R5 under `cfg_in_mode` and its own enable, independently of the output path.
- R7: A path enable select of 0 to 3 picks `gce[select]`. A select of 4 to 7 picks `io_ce`.
- R8: With `cfg_fix_en`=1, `pad_out` equals `cfg_fix_val` whatever the path result.
- R9: Once configured, `pad_oe` = `oe_src` XOR `cfg_oe_low`, so `cfg_oe_low`=1 makes `oe_src` active-low.
- R10: `pad_oe` is 0 in any cycle after a rising edge at which `cfg_done` was 0.
- R11: While `rst_n` is low, both stores are 0 and `pad_oe` is 0. Release takes effect two rising edges after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Configuration complete |
| cfg_in_mode | input | 2 | Input path mode |
| cfg_out_mode | input | 2 | Output path mode |
| cfg_in_ce_sel | input | 3 | Input path enable select |
| cfg_out_ce_sel | input | 3 | Output path enable select |
| cfg_casc_en | input | 1 | Cascade mode |
| cfg_fix_en | input | 1 | Fixed-level override on |
| cfg_fix_val | input | 1 | Fixed level |
| cfg_oe_low | input | 1 | Output enable is active-low |
| gce | input | 4 | Global enable lines |
| io_ce | input | 1 | Pin-derived enable |
| grp_in | input | 4 | Candidates from groups A..D |
| sel | input | 2 | Dynamic local select |
| casc_in | input | 4 | Local results of the four chained cells |
| casc_sel | input | 2 | Cascade (upper) select |
| pad_in | input | 1 | Value seen at the pad |
| oe_src | input | 1 | Raw output enable |
| in_to_grp | output | 1 | Input path result toward routing |
| casc_out | output | 1 | Local 4:1 result |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad drive enable |

## Verification
Combinational and transparent-latch results, the fixed level and the polarity of `pad_oe` are all due in the same cycle as their stimulus. The bench drives on the falling edge and checks 1 ns later, before the next rising edge. Stored values, and the configured gating of `pad_oe`, appear one rising edge after capture. The bench model updates its own stores and configured flag only at the rising edge, from the inputs held since the falling edge. Release from reset costs two rising edges. The bench holds all enables and `cfg_done` low through those edges before it resumes checking.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic [1:0] {
    PM_COMB  = 2'b00,
    PM_LATCH = 2'b01,
    PM_REG   = 2'b10,
    PM_RSVD  = 2'b11
  } path_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/xpt_rst_sync.sv
module xpt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/xpt_route_mux.sv
module xpt_route_mux #(
  parameter int unsigned N_GRP = 4,
  localparam int unsigned SEL_W = $clog2(N_GRP)
) (
  input  logic [N_GRP-1:0] grp_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             casc_en,
  input  logic [N_GRP-1:0] casc_in,
  input  logic [SEL_W-1:0] casc_sel,
  output logic             local_out,
  output logic             route
);

  logic [N_GRP-1:0] local_hit;
  logic [N_GRP-1:0] casc_hit;

  // One-hot decode per candidate, then OR-reduce: a single mux level.
  for (genvar g = 0; g < N_GRP; g++) begin : g_leg
    assign local_hit[g] = (sel == SEL_W'(g)) & grp_in[g];
    assign casc_hit[g]  = (casc_sel == SEL_W'(g)) & casc_in[g];
  end

  always_comb begin
    local_out = |local_hit;
    route     = casc_en ? (|casc_hit) : local_out;
  end

endmodule

// File: rtl/xpt_ce_select.sv
module xpt_ce_select #(
  parameter int unsigned N_GCE = 4,
  localparam int unsigned IDX_W = $clog2(N_GCE),
  localparam int unsigned CE_SEL_W = IDX_W + 1
) (
  input  logic [N_GCE-1:0]    gce,
  input  logic                io_ce,
  input  logic [CE_SEL_W-1:0] ce_sel,
  output logic                ce
);

  logic [IDX_W-1:0] idx;
  logic             use_io;

  always_comb begin
    idx    = ce_sel[IDX_W-1:0];
    use_io = ce_sel[CE_SEL_W-1];
    ce     = use_io ? io_ce : gce[idx];
  end

endmodule

// File: rtl/xpt_path_stage.sv
module xpt_path_stage
  import xpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  path_mode_e mode,
  input  logic       en,
  input  logic       d,
  output logic       store,
  output logic       y
);

  logic store_q;
  logic store_d;

  always_comb begin
    store_d = en ? d : store_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
    end else begin
      store_q <= store_d;
    end
  end

  always_comb begin
    unique case (mode)
      PM_LATCH: y = en ? d : store_q;
      PM_REG:   y = store_q;
      default:  y = d;
    endcase
  end

  assign store = store_q;

endmodule

// File: rtl/xpt_io_cell.sv
module xpt_io_cell
  import xpt_pkg::*;
#(
  parameter int unsigned N_GRP = 4,
  parameter int unsigned N_GCE = 4,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned SEL_W = $clog2(N_GRP),
  localparam int unsigned CE_SEL_W = $clog2(N_GCE) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_done,
  input  logic [MODE_W-1:0]   cfg_in_mode,
  input  logic [MODE_W-1:0]   cfg_out_mode,
  input  logic [CE_SEL_W-1:0] cfg_in_ce_sel,
  input  logic [CE_SEL_W-1:0] cfg_out_ce_sel,
  input  logic                cfg_casc_en,
  input  logic                cfg_fix_en,
  input  logic                cfg_fix_val,
  input  logic                cfg_oe_low,
  input  logic [N_GCE-1:0]    gce,
  input  logic                io_ce,
  input  logic [N_GRP-1:0]    grp_in,
  input  logic [SEL_W-1:0]    sel,
  input  logic [N_GRP-1:0]    casc_in,
  input  logic [SEL_W-1:0]    casc_sel,
  input  logic                pad_in,
  input  logic                oe_src,
  output logic                in_to_grp,
  output logic                casc_out,
  output logic                pad_out,
  output logic                pad_oe
);

  logic rst_sync_n;
  logic route;
  logic in_en;
  logic out_en;
  logic in_store;
  logic out_store;
  logic out_path;
  logic ready_q;
  logic ready_d;

  xpt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xpt_route_mux #(.N_GRP(N_GRP)) u_mux (
    .grp_in    (grp_in),
    .sel       (sel),
    .casc_en   (cfg_casc_en),
    .casc_in   (casc_in),
    .casc_sel  (casc_sel),
    .local_out (casc_out),
    .route     (route)
  );

  xpt_ce_select #(.N_GCE(N_GCE)) u_in_ce (
    .gce    (gce),
    .io_ce  (io_ce),
    .ce_sel (cfg_in_ce_sel),
    .ce     (in_en)
  );

  xpt_ce_select #(.N_GCE(N_GCE)) u_out_ce (
    .gce    (gce),
    .io_ce  (io_ce),
    .ce_sel (cfg_out_ce_sel),
    .ce     (out_en)
  );

  xpt_path_stage u_in_path (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .mode  (path_mode_e'(cfg_in_mode)),
    .en    (in_en),
    .d     (pad_in),
    .store (in_store),
    .y     (in_to_grp)
  );

  xpt_path_stage u_out_path (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .mode  (path_mode_e'(cfg_out_mode)),
    .en    (out_en),
    .d     (route),
    .store (out_store),
    .y     (out_path)
  );

  // Configured flag: pad stays undriven through reset and until cfg_done is seen.
  always_comb begin
    ready_d = cfg_done;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
    end
  end

  always_comb begin
    pad_out = cfg_fix_en ? cfg_fix_val : out_path;
    pad_oe  = ready_q & (oe_src ^ cfg_oe_low);
  end

endmodule

// File: rtl/xpt_io_cell_chk.sv
module xpt_io_cell_chk #(
  parameter int unsigned N_GRP = 4,
  localparam int unsigned SEL_W = $clog2(N_GRP)
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic             cfg_done,
  input logic [1:0]       cfg_out_mode,
  input logic             cfg_fix_en,
  input logic             cfg_fix_val,
  input logic             cfg_oe_low,
  input logic [N_GRP-1:0] grp_in,
  input logic [SEL_W-1:0] sel,
  input logic             oe_src,
  input logic             route,
  input logic             out_en,
  input logic             out_store,
  input logic             casc_out,
  input logic             pad_out,
  input logic             pad_oe
);

  AST_LOCAL_SELECT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    casc_out == grp_in[sel]); // R1

  AST_COMB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (cfg_out_mode == 2'b00 && !cfg_fix_en) |-> pad_out == route); // R3

  AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (cfg_out_mode == 2'b01 && out_en && !cfg_fix_en) |-> pad_out == route); // R4

  AST_STORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    out_en |=> out_store == $past(route)); // R5

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !out_en |=> $stable(out_store)); // R5

  AST_FIXED_LEVEL: assert property (@(posedge clk) disable iff (!rst_ok_n)
    cfg_fix_en |-> pad_out == cfg_fix_val); // R8

  AST_OE_POLARITY: assert property (@(posedge clk) disable iff (!rst_ok_n)
    cfg_done |=> pad_oe == (oe_src ^ cfg_oe_low)); // R9

  AST_OE_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !cfg_done |=> !pad_oe); // R10

endmodule

bind xpt_io_cell xpt_io_cell_chk #(.N_GRP(N_GRP)) u_chk (
  .clk          (clk),
  .rst_ok_n     (rst_sync_n),
  .cfg_done     (cfg_done),
  .cfg_out_mode (cfg_out_mode),
  .cfg_fix_en   (cfg_fix_en),
  .cfg_fix_val  (cfg_fix_val),
  .cfg_oe_low   (cfg_oe_low),
  .grp_in       (grp_in),
  .sel          (sel),
  .oe_src       (oe_src),
  .route        (route),
  .out_en       (out_en),
  .out_store    (out_store),
  .casc_out     (casc_out),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe)
);

// File: tb/tb_xpt_io_cell.sv
`timescale 1ns/1ps
module tb_xpt_io_cell;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_done;
  logic [1:0] cfg_in_mode, cfg_out_mode;
  logic [2:0] cfg_in_ce_sel, cfg_out_ce_sel;
  logic       cfg_casc_en, cfg_fix_en, cfg_fix_val, cfg_oe_low;
  logic [3:0] gce;
  logic       io_ce;
  logic [3:0] grp_in;
  logic [1:0] sel;
  logic [3:0] casc_in;
  logic [1:0] casc_sel;
  logic       pad_in, oe_src;
  logic       in_to_grp, casc_out, pad_out, pad_oe;

  int checks = 0;
  int failures = 0;
  logic m_in_q = 1'b0, m_out_q = 1'b0, m_ready = 1'b0;

  always #2.5 clk = ~clk;

  xpt_io_cell dut (.*);

  function automatic logic f_en(input logic [2:0] s, input logic [3:0] g, input logic io);
    return s[2] ? io : g[s[1:0]];
  endfunction

  function automatic logic f_route();
    return cfg_casc_en ? casc_in[casc_sel] : grp_in[sel];
  endfunction

  function automatic logic f_stage(input logic [1:0] m, input logic en, input logic d, input logic q);
    if (m == 2'b01) return en ? d : q;
    if (m == 2'b10) return q;
    return d;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string out_tag();
    string r;
    r = cfg_casc_en ? "R2" : "R1";
    if (cfg_fix_en) return {r, " R8"};
    if (cfg_out_mode == 2'b01) return {r, " R4 R7"};
    if (cfg_out_mode == 2'b10) return {r, " R5 R7"};
    return {r, " R3"};
  endfunction

  task automatic check_all();
    logic oen, ien, exp_out, exp_in, exp_oe;
    oen = f_en(cfg_out_ce_sel, gce, io_ce);
    ien = f_en(cfg_in_ce_sel, gce, io_ce);
    exp_out = cfg_fix_en ? cfg_fix_val : f_stage(cfg_out_mode, oen, f_route(), m_out_q);
    exp_in  = f_stage(cfg_in_mode, ien, pad_in, m_in_q);
    exp_oe  = m_ready & (oe_src ^ cfg_oe_low);
    check(out_tag(), pad_out, exp_out);
    check("R6 R7 input path", in_to_grp, exp_in);
    check(m_ready ? "R9 oe polarity" : "R10 oe unconfigured", pad_oe, exp_oe);
    check("R1 casc_out", casc_out, grp_in[sel]);
  endtask

  task automatic model_edge();
    logic oen, ien, r;
    oen = f_en(cfg_out_ce_sel, gce, io_ce);
    ien = f_en(cfg_in_ce_sel, gce, io_ce);
    r = f_route();
    if (oen) m_out_q = r;
    if (ien) m_in_q = pad_in;
    m_ready = cfg_done;
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic step_check();
    #1;
    check_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic randomize_inputs();
    cfg_done       = ($urandom % 8) != 0;
    cfg_in_mode    = 2'($urandom);
    cfg_out_mode   = 2'($urandom);
    cfg_in_ce_sel  = 3'($urandom);
    cfg_out_ce_sel = 3'($urandom);
    cfg_casc_en    = ($urandom % 3) == 0;
    cfg_fix_en     = ($urandom % 8) == 0;
    cfg_fix_val    = 1'($urandom);
    cfg_oe_low     = 1'($urandom);
    gce            = 4'($urandom);
    io_ce          = 1'($urandom);
    grp_in         = 4'($urandom);
    sel            = 2'($urandom);
    casc_in        = 4'($urandom);
    casc_sel       = 2'($urandom);
    pad_in         = 1'($urandom);
    oe_src         = 1'($urandom);
  endtask

  task automatic quiet_inputs();
    cfg_done = 0; cfg_in_mode = 2'b10; cfg_out_mode = 2'b10;
    cfg_in_ce_sel = 3'd0; cfg_out_ce_sel = 3'd0; cfg_casc_en = 0;
    cfg_fix_en = 0; cfg_fix_val = 0; cfg_oe_low = 1;
    gce = 4'b0; io_ce = 0; grp_in = 4'hF; sel = 0; casc_in = 4'hF;
    casc_sel = 0; pad_in = 1; oe_src = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    quiet_inputs();
    rst_n = 0;
    #1;
    check("R11 reset pad_out", pad_out, 1'b0);
    check("R11 reset in_to_grp", in_to_grp, 1'b0);
    check("R11 reset pad_oe", pad_oe, 1'b0);
    m_in_q = 0; m_out_q = 0; m_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R11 after release pad_out", pad_out, 1'b0);
    check("R11 after release pad_oe", pad_oe, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    quiet_inputs();
    do_reset();

    // R10: configured flag lags cfg_done by one edge
    cfg_done = 1; oe_src = 1; cfg_oe_low = 0;
    step_check();
    check("R9 oe after cfg_done", pad_oe, 1'b1);
    cfg_oe_low = 1; #1;
    check("R9 active-low oe", pad_oe, 1'b0);

    // R1: every local select, each group
    cfg_out_mode = 2'b00;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      sel = 2'(s); grp_in = 4'(1 << s);
      step_check();
    end

    // R2: cascade pick of every upper select
    cfg_casc_en = 1; grp_in = 4'h0;
    for (int s = 0; s < 4; s++) begin
      casc_sel = 2'(s); casc_in = ~4'(1 << s);
      step_check();
    end
    cfg_casc_en = 0;

    // R4: latch transparent then hold
    cfg_out_mode = 2'b01; cfg_out_ce_sel = 3'd2; gce = 4'b0100;
    grp_in = 4'hF; sel = 1;
    step_check();
    gce = 4'b0000; grp_in = 4'h0;
    step_check();
    #0 check("R4 latch hold value", pad_out, 1'b1);

    // R5 and R7: registered, enable from io_ce
    cfg_out_mode = 2'b10; cfg_out_ce_sel = 3'd5; io_ce = 0; grp_in = 4'h0;
    step_check();
    check("R5 R7 hold with enable low", pad_out, 1'b1);
    io_ce = 1;
    step_check();
    check("R5 R7 captured zero", pad_out, 1'b0);

    // R8: fixed levels
    cfg_fix_en = 1; cfg_fix_val = 1; step_check();
    cfg_fix_val = 0; grp_in = 4'hF; cfg_out_mode = 2'b00; step_check();
    cfg_fix_en = 0;

    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      step_check();
    end

    // R11: reset in the middle of operation
    do_reset();
    for (int i = 0; i < 500; i++) begin
      randomize_inputs();
      step_check();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule